// File: doc/BRIEF.md
# Prescaled 16-bit Timer and Event Counter

The block is a 16-bit up-counter with two selectable sources. In timer mode it advances on an internal enable that fires once every four system clocks. In counter mode it advances on rising edges of an external input. The external input is first brought into the system clock domain by a two-flop synchronizer and then passed through an edge detector. The selected source then goes through a prescaler that divides by 1, 2, 4 or 8. In counter mode, the prescaler output can optionally pass through one more resynchronizing register before it reaches the count stage.

Control is through four byte-wide registers on an 8-bit access port. A run bit freezes or releases the count. A sticky flag records each wrap from 0xFFFF to 0x0000. A special-event input from a compare unit forces the count to zero. An optional paired-access mode routes the high byte through a holding register, so that software can read or write all 16 bits consistently with two byte accesses.

Register map (acc_addr): 0 = count low byte, 1 = count high byte (the holding register in paired mode), 2 = control, 3 = status. Control fields: bit0 run, bit1 source (1 = external edges), bit2 resync bypass (1 = skip the extra register), bits 5:4 prescale code, bit7 paired-access mode. Status bit0 is the wrap flag.

The access port is a valid/ready channel. acc_ready is always high, so a request is accepted in every cycle in which acc_valid is high, and the bus never applies back-pressure. Write requests take effect at that clock edge. Read data on acc_rdata is valid in the same cycle as the request.

Top module: `event_timer16`

## Requirements
- R1: With source = 0 and prescale code 00, the count advances exactly K times in any 4*K consecutive clock edges during which run is 1.
- R2: Prescale codes 00, 01, 10 and 11 (control bits 5:4) divide the selected source by 1, 2, 4 and 8 respectively.
- R3: With source = 1, each low-to-high transition of ext_in advances the source by exactly one, no matter how long the input stays high.
- R4: With code 00, the count changes at the second clock edge after the first edge that samples ext_in high when the resync bypass is 1, and at the third such edge when the bypass is 0.
- R5: While run is 0, the count holds its value whatever happens on ext_in.
- R6: An advance from 0xFFFF leaves the count at 0x0000 and sets the wrap flag (status bit0).
- R7: The wrap flag stays set until a status write with bit0 = 0. A new wrap in the same cycle as that write leaves the flag set.
- R8: A one-cycle pulse on evt_clr sets the count to 0x0000. A count write in the same cycle takes priority.
- R9: With bit7 = 0, addresses 0 and 1 read and write the count's low and high bytes directly.
- R10: With bit7 = 1, a read of address 0 copies the count's high byte into the holding register, and a read of address 1 returns the holding register.
- R11: With bit7 = 1, a write of address 1 changes only the holding register, and a write of address 0 loads {holding register, written byte} into the count in one cycle.
- R12: Any count write or control write resets the prescaler's partial count.
- R13: After reset, the count, control, status and holding register are all zero, and acc_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 1 | External event input, asynchronous to clk |
| evt_clr | input | 1 | Special-event clear pulse from a compare unit |
| acc_valid | input | 1 | Register access request valid |
| acc_ready | output | 1 | Access accepted (always 1) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Register select |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid with the request |

## Verification
The hardest behaviour to reach from the ports is the one-cycle difference between the resynchronized and bypassed external paths. It only shows up if the count is observed in each individual cycle just after an input edge. The stimulus raises ext_in just after a clock edge, then issues back-to-back reads of the low byte (which are side-effect free in byte mode), so each cycle's count is compared against the expected edge position for both settings. The paired-mode holding register is reached in a similar way: a low-byte read is followed by an evt_clr pulse before the high byte is read, so that a stale and a live high byte give different answers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PS_W = 2;

  typedef enum logic [1:0] {
    A_LOW  = 2'd0,
    A_HIGH = 2'd1,
    A_CTRL = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic            paired;
    logic [PS_W-1:0] ps;
    logic            bypass;
    logic            ext_sel;
    logic            run;
  } ctrl_t;
endpackage

// File: rtl/tmr_src.sv
module tmr_src #(
  parameter int QUARTER     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic ext_sel,
  output logic tick
);
  localparam int QW = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  logic [QW-1:0]          q_cnt;
  logic                   q_tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;
  logic                   ext_rise;

  assign q_tick = (q_cnt == QW'(QUARTER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_cnt <= '0;
    else if (q_tick) q_cnt <= '0;
    else             q_cnt <= q_cnt + 1'b1;
  end

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ext_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b0;
    else        ext_prev <= sync_q[SYNC_STAGES-1];
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev;
  assign tick     = ext_sel ? ext_rise : q_tick;

  // R3: one input edge yields a single-cycle source pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
  // R1: internal enable never fires two cycles running
  a_r1_quarter_gap: assert property (@(posedge clk) disable iff (!rst_n)
    q_tick |=> !q_tick);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int CW = (1 << PS_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic [PS_W-1:0] ps,
  output logic            out
);
  logic [CW-1:0] pcnt;
  logic [CW-1:0] last;

  assign last = ~({CW{1'b1}} << ps);
  assign out  = adv & (pcnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (adv) pcnt <= out ? '0 : pcnt + 1'b1;
  end

  // R12: a clear empties the partial count
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt == '0));
  // R2: partial count never passes the selected divide limit
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= last);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             use_resync,
  input  logic             pre_out,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             evt_clr,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             flag
);
  logic rs_q;
  logic inc;
  logic wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 1'b0;
    else        rs_q <= run & pre_out;
  end

  assign inc  = run & (use_resync ? rs_q : pre_out);
  assign wrap = inc & ~ld_en & ~evt_clr & (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (ld_en)   count <= ld_val;
    else if (evt_clr) count <= '0;
    else if (inc)     count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (wrap)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  // R6: a wrap lands at zero with the flag raised
  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (flag && count == '0));
  // R7: flag holds without a software clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  // R5: stopped counter holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_en && !evt_clr) |=> $stable(count));
  // R8: special event clears the count
  a_r8_evt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !ld_en) |=> (count == '0));
  // R8: a write beats the special event
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (count == $past(ld_val)));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_addr,
  input  logic [BUS_W-1:0] acc_wdata,
  output logic [BUS_W-1:0] acc_rdata,
  input  logic [CNT_W-1:0] count,
  input  logic             flag,
  output ctrl_t            ctrl,
  output logic             ld_en,
  output logic [CNT_W-1:0] ld_val,
  output logic             flag_clr,
  output logic             psc_clr
);
  logic             wr;
  logic             rd;
  logic [BUS_W-1:0] hbuf;
  reg_addr_e        addr;
  logic [7:0]       ctrl_rd;

  assign addr = reg_addr_e'(acc_addr);
  assign wr   = acc_valid & acc_write;
  assign rd   = acc_valid & ~acc_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr && addr == A_CTRL) begin
      ctrl.run     <= acc_wdata[0];
      ctrl.ext_sel <= acc_wdata[1];
      ctrl.bypass  <= acc_wdata[2];
      ctrl.ps      <= acc_wdata[5:4];
      ctrl.paired  <= acc_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hbuf <= '0;
    end else if (ctrl.paired) begin
      if (wr && addr == A_HIGH)     hbuf <= acc_wdata;
      else if (rd && addr == A_LOW) hbuf <= count[CNT_W-1:BUS_W];
    end
  end

  assign ld_en = wr & ((addr == A_LOW) | ((addr == A_HIGH) & ~ctrl.paired));

  always_comb begin
    if (addr == A_HIGH)   ld_val = {acc_wdata, count[BUS_W-1:0]};
    else if (ctrl.paired) ld_val = {hbuf, acc_wdata};
    else                  ld_val = {count[CNT_W-1:BUS_W], acc_wdata};
  end

  assign flag_clr = wr & (addr == A_STAT) & ~acc_wdata[0];
  assign psc_clr  = ld_en | (wr & (addr == A_CTRL));

  assign ctrl_rd = {ctrl.paired, 1'b0, ctrl.ps, 1'b0, ctrl.bypass, ctrl.ext_sel, ctrl.run};

  always_comb begin
    unique case (addr)
      A_LOW:   acc_rdata = count[BUS_W-1:0];
      A_HIGH:  acc_rdata = ctrl.paired ? hbuf : count[CNT_W-1:BUS_W];
      A_CTRL:  acc_rdata = BUS_W'(ctrl_rd);
      default: acc_rdata = BUS_W'(flag);
    endcase
  end

  // R10: paired low-byte read snapshots the high byte
  a_r10_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_LOW && ctrl.paired) |=> (hbuf == $past(count[CNT_W-1:BUS_W])));
  // R11: paired high-byte write leaves the count alone
  a_r11_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_HIGH && ctrl.paired) |-> !ld_en);
endmodule

// File: rtl/event_timer16.sv
module event_timer16
  import tmr_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int QUARTER     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_in,
  input  logic             evt_clr,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic             acc_write,
  input  logic [1:0]       acc_addr,
  input  logic [BUS_W-1:0] acc_wdata,
  output logic [BUS_W-1:0] acc_rdata
);
  localparam int CNT_W = 2 * BUS_W;

  ctrl_t            ctrl;
  logic             tick;
  logic             pre_out;
  logic             ld_en;
  logic [CNT_W-1:0] ld_val;
  logic             flag_clr;
  logic             psc_clr;
  logic [CNT_W-1:0] count;
  logic             flag;

  assign acc_ready = 1'b1;

  tmr_src #(.QUARTER(QUARTER), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .ext_sel(ctrl.ext_sel), .tick(tick)
  );

  tmr_prescale u_psc (
    .clk(clk), .rst_n(rst_n), .clr(psc_clr), .adv(tick & ctrl.run),
    .ps(ctrl.ps), .out(pre_out)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run),
    .use_resync(ctrl.ext_sel & ~ctrl.bypass), .pre_out(pre_out),
    .ld_en(ld_en), .ld_val(ld_val), .evt_clr(evt_clr), .flag_clr(flag_clr),
    .count(count), .flag(flag)
  );

  tmr_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .count(count), .flag(flag), .ctrl(ctrl), .ld_en(ld_en), .ld_val(ld_val),
    .flag_clr(flag_clr), .psc_clr(psc_clr)
  );

  // R13: accesses are never stalled
  a_r13_ready: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> acc_ready);
endmodule

// File: tb/test_event_timer16.sv
module test_event_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_in = 1'b0;
  logic       evt_clr = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_ready;
  logic       acc_write = 1'b0;
  logic [1:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;

  int checks = 0;
  int fails = 0;
  logic chk = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  event_timer16 i_event_timer16 (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .evt_clr(evt_clr),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
  );

  // monitor: compares each checked read against the scoreboard head
  always @(negedge clk) begin
    if (chk) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (acc_rdata !== it.exp || acc_ready !== 1'b1) begin
        fails++;
        $display("FAIL %s: got %h (ready %b) expected %h", it.tag, acc_rdata, acc_ready, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; chk = 1'b1;
    @(posedge clk); #1;
    acc_valid = 1'b0; chk = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_in = 1'b1; idle(5);
      ext_in = 1'b0; idle(4);
    end
    idle(6);
  endtask

  // timer window of exactly 4*k enabled edges
  task automatic timer_run(input logic [1:0] ps, input int k);
    wr(2'd2, {2'b00, ps, 4'b0001});
    idle(4 * k - 1);
    wr(2'd2, {2'b00, ps, 4'b0000});
  endtask

  task automatic set_count(input logic [7:0] hi, input logic [7:0] lo);
    wr(2'd0, lo); wr(2'd1, hi);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R13 reset state
    rd(2'd0, 8'h00, "R13 count low after reset");
    rd(2'd1, 8'h00, "R13 count high after reset");
    rd(2'd2, 8'h00, "R13 control after reset");
    rd(2'd3, 8'h00, "R13 status after reset");

    // R1 timer rate, R2 divide ratios
    timer_run(2'b00, 16);
    rd(2'd0, 8'd16, "R1 timer 64 edges prescale 1");
    set_count(8'h00, 8'h00);
    timer_run(2'b01, 16);
    rd(2'd0, 8'd8, "R2 timer prescale 2");
    set_count(8'h00, 8'h00);
    timer_run(2'b10, 16);
    rd(2'd0, 8'd4, "R2 timer prescale 4");
    set_count(8'h00, 8'h00);
    timer_run(2'b11, 16);
    rd(2'd0, 8'd2, "R2 timer prescale 8");

    // R3 external edges, long high levels count once
    set_count(8'h00, 8'h00);
    wr(2'd2, 8'h03);
    pulses(5);
    rd(2'd0, 8'd5, "R3 five external pulses");
    set_count(8'h00, 8'h00);
    wr(2'd2, 8'h07);
    ext_in = 1'b1; idle(30); ext_in = 1'b0; idle(6);
    rd(2'd0, 8'd1, "R3 held high counts once");
    set_count(8'h00, 8'h00);
    wr(2'd2, 8'h13);
    pulses(8);
    rd(2'd0, 8'd4, "R2 external prescale 2");

    // R12 control write drops prescaler progress
    set_count(8'h00, 8'h00);
    wr(2'd2, 8'h23);
    pulses(3);
    wr(2'd2, 8'h23);
    pulses(1);
    rd(2'd0, 8'd0, "R12 prescaler cleared by control write");
    pulses(3);
    rd(2'd0, 8'd1, "R12 count after four fresh pulses");

    // R4 latency, bypassed then resynchronized
    for (int m = 0; m < 2; m++) begin
      wr(2'd2, m == 0 ? 8'h07 : 8'h03);
      set_count(8'h00, 8'h00);
      idle(2);
      ext_in = 1'b1;
      idle(2);
      rd(2'd0, 8'd0, "R4 before update");
      rd(2'd0, m == 0 ? 8'd1 : 8'd0, "R4 second edge after sampling");
      rd(2'd0, 8'd1, "R4 third edge after sampling");
      ext_in = 1'b0; idle(6);
    end

    // R5 hold while stopped
    wr(2'd2, 8'h02);
    set_count(8'h00, 8'h09);
    pulses(4);
    rd(2'd0, 8'h09, "R5 stopped counter holds");

    // R9 byte access, R6 wrap, R7 flag
    wr(2'd2, 8'h00);
    set_count(8'hFF, 8'hFE);
    rd(2'd1, 8'hFF, "R9 high byte direct");
    rd(2'd0, 8'hFE, "R9 low byte direct");
    timer_run(2'b00, 2);
    rd(2'd0, 8'h00, "R6 low after wrap");
    rd(2'd1, 8'h00, "R6 high after wrap");
    rd(2'd3, 8'h01, "R6 flag set by wrap");
    idle(10);
    rd(2'd3, 8'h01, "R7 flag stays set");
    wr(2'd3, 8'h01);
    rd(2'd3, 8'h01, "R7 write of 1 keeps flag");
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00, "R7 flag cleared");

    // R8 special event clear
    set_count(8'h12, 8'h34);
    @(negedge clk); evt_clr = 1'b1; @(posedge clk); #1; evt_clr = 1'b0;
    rd(2'd0, 8'h00, "R8 low cleared by event");
    rd(2'd1, 8'h00, "R8 high cleared by event");
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 2'd0; acc_wdata = 8'h5A; evt_clr = 1'b1;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0; evt_clr = 1'b0;
    rd(2'd0, 8'h5A, "R8 write wins over event");

    // R11 paired write, R10 paired read
    wr(2'd2, 8'h80);
    wr(2'd1, 8'hAB);
    wr(2'd2, 8'h00);
    rd(2'd1, 8'h00, "R11 high write only touches holding register");
    wr(2'd2, 8'h80);
    wr(2'd0, 8'hCD);
    rd(2'd0, 8'hCD, "R11 low write loads count");
    rd(2'd1, 8'hAB, "R10 high from snapshot");
    rd(2'd0, 8'hCD, "R10 low read snapshots");
    @(negedge clk); evt_clr = 1'b1; @(posedge clk); #1; evt_clr = 1'b0;
    rd(2'd1, 8'hAB, "R10 snapshot survives count change");
    rd(2'd0, 8'h00, "R10 low after clear");
    rd(2'd1, 8'h00, "R10 fresh snapshot");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule